// File: doc/BRIEF.md
# Byte-Lane SRAM with Sleep Sequencer

A synchronous on-chip memory whose words are split into byte lanes. Each lane is nine bits wide: eight data bits and one parity bit. One parameter sets the number of lanes, four by default or two for the narrow build. A cycle is a read when the active-low write enable is high. When it is low, each lane whose active-low byte-write select is low takes new data. Any mix of lanes can be written in one cycle, and the lanes not selected keep their old contents.

A sleep request input arrives asynchronously and passes through a two-flop synchronizer. A four-phase sequencer (awake, entering, asleep, recovering) acts on the synchronized request. It takes a fixed two-cycle entry and a fixed two-cycle recovery. Memory access is allowed only while the block is fully awake and no synchronized request is pending. An access made during entry is dropped and flagged. An enable or strobe asserted during recovery is also dropped and flagged. Stored contents are never disturbed by sleep.

Top module: `lane_sram_sleep`

## Requirements
- R1: An access happens when cs_i is 1 and at least one of strb_a_i, strb_b_i is 1. An access with wr_ni = 1 is a read whatever bw_ni holds. The stored word appears on rdata_o in the cycle after the read edge, and no byte changes.
- R2: An access with wr_ni = 0 writes lane i (bits 9*i+8 down to 9*i of the word) exactly when bw_ni[i] = 0. All other lanes keep their value.
- R3: An access with wr_ni = 0 and every bw_ni bit at 1 leaves the addressed word unchanged.
- R4: After sleep_i rises, the request reaches the sequencer on the second clock edge. Entry then lasts two cycles, so asleep_o goes high after the fifth edge counted from the change of sleep_i.
- R5: After sleep_i falls, asleep_o goes low after the fifth edge. Recovery lasts two cycles. An access in the first cycle after that is accepted.
- R6: Stored words keep their values through entry, sleep and recovery.
- R7: An access is accepted only while the sequencer is awake and the synchronized request is low. Any other access, and any cycle with cs_i = 0, changes no word.
- R8: err_o is high for one cycle after an edge where cs_i was 1 during entry, or where any of cs_i, strb_a_i, strb_b_i was 1 during recovery. Entry here means the awake cycle in which the synchronized request is high, plus the two entry cycles. Such an edge also counts as a dropped access. Otherwise err_o is 0.
- R9: rdata_o is all zero except in the cycle after an accepted read. It is therefore zero while asleep or recovering.
- R10: While rst_ni is low and right after it, rdata_o, asleep_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Asynchronous sleep request, active high |
| cs_i | input | 1 | Chip select, active high |
| strb_a_i | input | 1 | Address strobe A, active high |
| strb_b_i | input | 1 | Address strobe B, active high |
| wr_ni | input | 1 | Write enable, active low (1 = read) |
| bw_ni | input | LANES | Byte-write selects, active low, one per lane |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*9 | Write data, lane i at bits 9*i+8:9*i |
| rdata_o | output | LANES*9 | Read data, one cycle after the read |
| asleep_o | output | 1 | High while asleep or recovering |
| err_o | output | 1 | One-cycle pulse for a dropped access in entry or recovery |

## Verification
The sharpest collision is a write issued on the same cycle that the synchronized sleep request shows up. The bench raises sleep_i while it drives a write to one address on every cycle. The writes from the first two edges must land. The write on the third edge and the two entry writes must be dropped, each with an error pulse, and a read-back after wake must show the data from the second edge. A second collision is recovery overlapping a strobe. It is judged by err_o, by the exact edge where asleep_o falls, and by a free-running behavioural model compared on every clock during a long pseudo-random phase that toggles sleep_i.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
  typedef enum logic [1:0] {
    PH_AWAKE   = 2'd0,
    PH_ENTER   = 2'd1,
    PH_ASLEEP  = 2'd2,
    PH_RECOVER = 2'd3
  } slp_phase_e;

  localparam int unsigned LANE_W = 9;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], async_i};
  end

  assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import lane_sram_pkg::*;
#(
  parameter int unsigned ENTER_CYC = 2,
  parameter int unsigned REC_CYC   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic ready_o,
  output logic entry_o,
  output logic recov_o,
  output logic asleep_o
);
  localparam int unsigned MAXC = (ENTER_CYC > REC_CYC) ? ENTER_CYC : REC_CYC;
  localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] ENT_LAST = CW'(ENTER_CYC - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);

  slp_phase_e    phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_AWAKE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_AWAKE: if (req_i) begin
          phase_q <= PH_ENTER;
          cnt_q   <= '0;
        end
        PH_ENTER: if (cnt_q == ENT_LAST) phase_q <= PH_ASLEEP;
                  else                   cnt_q   <= cnt_q + 1'b1;
        PH_ASLEEP: if (!req_i) begin
          phase_q <= PH_RECOVER;
          cnt_q   <= '0;
        end
        PH_RECOVER: if (cnt_q == REC_LAST) phase_q <= PH_AWAKE;
                    else                   cnt_q   <= cnt_q + 1'b1;
        default: phase_q <= PH_AWAKE;
      endcase
    end
  end

  // request already seen in the awake phase counts as entry start
  assign ready_o  = (phase_q == PH_AWAKE) && !req_i;
  assign entry_o  = ((phase_q == PH_AWAKE) && req_i) || (phase_q == PH_ENTER);
  assign recov_o  = (phase_q == PH_RECOVER);
  assign asleep_o = (phase_q == PH_ASLEEP) || (phase_q == PH_RECOVER);

  assert_entry_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep_o) |-> ($past(phase_q) == PH_ENTER) && ($past(cnt_q) == ENT_LAST));

  assert_recover_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(asleep_o) |-> ($past(phase_q) == PH_RECOVER) && ($past(cnt_q) == REC_LAST));
endmodule

// File: rtl/lane_ram.sv
module lane_ram #(
  parameter int unsigned W  = 9,
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

  // lane holds its word on any cycle without a lane write
  assert_lane_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (addr_i != $past(addr_i)) || (rdata_o == $past(rdata_o)));
endmodule

// File: rtl/lane_sram_sleep.sv
module lane_sram_sleep
  import lane_sram_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned SYNC_FF   = 2,
  parameter int unsigned ENTER_CYC = 2,
  parameter int unsigned REC_CYC   = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sleep_i,
  input  logic                      cs_i,
  input  logic                      strb_a_i,
  input  logic                      strb_b_i,
  input  logic                      wr_ni,
  input  logic [LANES-1:0]          bw_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  output logic [LANES*LANE_W-1:0]   rdata_o,
  output logic                      asleep_o,
  output logic                      err_o
);
  localparam int unsigned DW = LANES * LANE_W;

  logic req_sync, ready, entry, recov;
  logic acc, rd_acc, wr_acc, err_d;
  logic [LANES-1:0] lane_we;
  logic [DW-1:0]    word;
  logic [DW-1:0]    rdata_q;
  logic             err_q;

  sleep_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sleep_i),
    .sync_o (req_sync)
  );

  sleep_seq #(.ENTER_CYC(ENTER_CYC), .REC_CYC(REC_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_sync),
    .ready_o (ready),
    .entry_o (entry),
    .recov_o (recov),
    .asleep_o(asleep_o)
  );

  assign acc    = cs_i && (strb_a_i || strb_b_i);
  assign rd_acc = ready && acc && wr_ni;
  assign wr_acc = ready && acc && !wr_ni;
  assign err_d  = (entry && cs_i) || (recov && (cs_i || strb_a_i || strb_b_i));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = wr_acc && !bw_ni[g];
    lane_ram #(.W(LANE_W), .AW(ADDR_W)) u_ram (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (lane_we[g]),
      .addr_i (addr_i),
      .wdata_i(wdata_i[g*LANE_W +: LANE_W]),
      .rdata_o(word[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rd_acc ? word : '0;
      err_q   <= err_d;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  assert_rdata_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o |-> (rdata_o == '0));

  assert_err_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$past(ready));

  assert_read_no_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ni |-> (lane_we == '0));
endmodule

// File: tb/sim_lane_sram_sleep.sv
`timescale 1ns/1ps
module sim_lane_sram_sleep;
  localparam int LANES = 4;
  localparam int AW    = 6;
  localparam int DW    = LANES * 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep = 1'b0, cs = 1'b0, sa = 1'b0, sb = 1'b0, wn = 1'b1;
  logic [LANES-1:0] bw = '1;
  logic [AW-1:0]    addr = '0;
  logic [DW-1:0]    wd = '0;
  logic [DW-1:0]    rdata;
  logic             asleep, err;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  lane_sram_sleep #(.LANES(LANES), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .cs_i(cs), .strb_a_i(sa),
    .strb_b_i(sb), .wr_ni(wn), .bw_ni(bw), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata), .asleep_o(asleep), .err_o(err)
  );

  // behavioural reference
  logic [DW-1:0] m_mem [1 << AW];
  logic [DW-1:0] m_rd;
  int m_s1, m_s2, m_ph, m_cnt;
  bit m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_ph = 0; m_cnt = 0; m_rd = '0; m_err = 0;
    end else begin
      bit ok, ent;
      ok    = (m_ph == 0) && (m_s2 == 0);
      ent   = ((m_ph == 0) && (m_s2 == 1)) || (m_ph == 1);
      m_err = (ent && cs) || ((m_ph == 3) && (cs || sa || sb));
      m_rd  = '0;
      if (ok && cs && (sa || sb)) begin
        if (wn) m_rd = m_mem[addr];
        else for (int i = 0; i < LANES; i++)
          if (!bw[i]) m_mem[addr][i*9 +: 9] = wd[i*9 +: 9];
      end
      case (m_ph)
        0: if (m_s2 == 1) begin m_ph = 1; m_cnt = 0; end
        1: if (m_cnt == 1) m_ph = 2; else m_cnt++;
        2: if (m_s2 == 0) begin m_ph = 3; m_cnt = 0; end
        default: if (m_cnt == 1) m_ph = 0; else m_cnt++;
      endcase
      m_s2 = m_s1;
      m_s1 = int'(sleep);
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R9 rdata vs model", 64'(rdata), 64'(m_rd));
      chk("R4/R5 asleep vs model", 64'(asleep), 64'((m_ph == 2) || (m_ph == 3)));
      chk("R8 err vs model", 64'(err), 64'(m_err));
    end
  end

  task automatic drive(input logic c, input logic a, input logic b, input logic w,
                       input logic [LANES-1:0] m, input logic [AW-1:0] ad,
                       input logic [DW-1:0] d);
    @(negedge clk);
    cs = c; sa = a; sb = b; wn = w; bw = m; addr = ad; wd = d;
  endtask

  task automatic idle();
    drive(0, 0, 0, 1, '1, '0, '0);
  endtask

  task automatic rd_chk(input logic [AW-1:0] ad, input logic [DW-1:0] exp, input string tag);
    drive(1, 1, 0, 1, '0, ad, '0);
    @(posedge clk); #1;
    chk(tag, 64'(rdata), 64'(exp));
  endtask

  function automatic logic [DW-1:0] pat(input int k);
    return {4{9'(k * 37 + 5)}} ^ DW'(k * 64'h1_2345_6789);
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset rdata", 64'(rdata), 0);
    chk("R10 reset asleep", 64'(asleep), 0);
    chk("R10 reset err", 64'(err), 0);
    @(negedge clk); rst_n = 1'b1;
    cmp_on = 1'b1;
    @(posedge clk); #1;
    chk("R10 after reset rdata", 64'(rdata), 0);

    // fill every word, full-lane writes
    for (int a = 0; a < (1 << AW); a++) drive(1, a[0], !a[0], 0, '0, AW'(a), pat(a));
    idle();
    for (int a = 0; a < 8; a++) rd_chk(AW'(a), pat(a), "R2 full write readback");

    // R2 partial lanes 0 and 2
    v = pat(3);
    drive(1, 1, 0, 0, 4'b1010, 6'd3, {DW{1'b1}});
    v[0 +: 9] = 9'h1FF; v[18 +: 9] = 9'h1FF;
    rd_chk(6'd3, v, "R2 lanes 0,2 merged");

    // R3 no-byte write
    drive(1, 1, 1, 0, 4'b1111, 6'd4, '0);
    rd_chk(6'd4, pat(4), "R3 no-byte write");

    // R1 read with all byte selects low does not write
    drive(1, 0, 1, 1, 4'b0000, 6'd4, '0);
    rd_chk(6'd4, pat(4), "R1 read ignores bw");

    // R7 strobes without select, select without strobes
    drive(0, 1, 1, 0, '0, 6'd2, '0);
    drive(1, 0, 0, 0, '0, 6'd2, '0);
    rd_chk(6'd2, pat(2), "R7 unselected write ignored");
    idle();
    @(posedge clk); #1;
    chk("R9 zero without read", 64'(rdata), 0);

    // entry collides with writes to address 5
    @(negedge clk); sleep = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      if (k > 1) @(negedge clk);
      cs = 1; sa = 1; sb = 0; wn = 0; bw = '0; addr = 6'd5; wd = pat(100 + k);
      @(posedge clk); #1;
      chk("R4 asleep at edge k", 64'(asleep), 64'(k >= 5));
      chk("R8 err in entry", 64'(err), 64'((k >= 3) && (k <= 5)));
    end
    // R7 write while asleep
    drive(1, 1, 1, 0, '0, 6'd6, '0);
    @(posedge clk); #1;
    chk("R8 no err while asleep", 64'(err), 0);
    chk("R9 rdata zero asleep", 64'(rdata), 0);

    // recovery with strobe A held
    @(negedge clk); sleep = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      if (k > 1) @(negedge clk);
      cs = 0; sa = 1; sb = 0; wn = 1; bw = '1; addr = '0; wd = '0;
      @(posedge clk); #1;
      chk("R5 asleep at edge k", 64'(asleep), 64'(k <= 4));
      chk("R8 err in recovery", 64'(err), 64'((k == 4) || (k == 5)));
    end
    rd_chk(6'd5, pat(102), "R5 first access after wake; R8 dropped entry writes");
    rd_chk(6'd6, pat(6), "R7 sleeping write dropped");
    for (int a = 0; a < 3; a++) rd_chk(AW'(a), pat(a), "R6 contents kept");
    rd_chk(6'd3, v, "R6 partial word kept");

    // pseudo-random phase against the model
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] r;
      r = $urandom;
      @(negedge clk);
      if ((c % 53) == 0) sleep = ~sleep;
      cs = r[0] | r[1]; sa = r[2]; sb = r[3] & r[4]; wn = r[5];
      bw = r[9:6]; addr = r[15:10]; wd = {r[31:16], r};
    end
    @(negedge clk); sleep = 1'b0;
    repeat (12) idle();
    for (int a = 0; a < (1 << AW); a++) begin
      drive(1, 1, 0, 1, '0, AW'(a), '0);
      @(posedge clk); #1;
      chk("R6 final contents vs model", 64'(rdata), 64'(m_rd));
    end
    idle();
    @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule